// File: doc/BRIEF.md
# Programmable 3x3 Color Matrix Converter

This block converts one pixel per clock from one three-component color space to another. Every output component is a signed weighted sum of the three input components plus a constant. The result is rounded to the nearest integer and clamped to the unsigned pixel range. A typical use is turning luma/chroma video into RGB ahead of a blender. The same hardware can perform any other 3x3 affine color transform.

Twelve 32-bit coefficient words are written one at a time through a simple indexed write port into a staging bank. The staged words, the enable bit and the format bit become active only on a frame-start strobe, so one frame never uses a mix of two coefficient sets.

Two coefficient formats are supported. The fixed-offset format uses signed factors with 10 fractional bits and a per-row signed constant with 10 fractional bits. The offset-pair format uses factors with 17 fractional bits, and each row's fourth word packs two signed values: a signed input offset that is added before multiplication, and a constant that is added after the sum. When the converter is disabled, pixels pass through unchanged with the same latency.

Top module: `csc_matrix3`

## Requirements
- R1: In fixed-offset format (active format bit 0), output row i equals (w[4i]·x + w[4i+1]·y + w[4i+2]·z + w[4i+3]) / 2^10. All words are signed 32-bit values. Inputs x, y, z are in_c0, in_c1, in_c2, and row i drives out_ci.
- R2: In offset-pair format (active format bit 1), word w[4i+3] carries a signed offset d_i in bits 31:16 and a signed constant k_i in bits 15:0. The offset d0 applies to x, d1 to y and d2 to z. Output row i equals (w[4i]·(x+d0) + w[4i+1]·(y+d1) + w[4i+2]·(z+d2)) / 2^17 + k_i, with k_i in output LSB units.
- R3: Each output is rounded to nearest by adding half an output LSB before an arithmetic right shift. A result of exactly .5 rounds up.
- R4: Each output is clamped to the range 0..1023. A negative result gives 0, and a result above 1023 gives 1023.
- R5: out_valid follows in_valid by exactly 3 clock cycles. A pixel's result appears in the cycle in which its out_valid is high.
- R6: When the active enable is 0, out_c0..out_c2 equal the input components presented 3 cycles earlier.
- R7: A write with wr_en high and wr_idx in 0..11 stores wr_data in staging word wr_idx. Words are row-major: c00 c01 c02 k0, c10 c11 c12 k1, c20 c21 c22 k2. A write with wr_idx of 12..15 changes no word.
- R8: Staged words have no effect until frame_start is high. A pixel presented in the same cycle as frame_start already uses the new set. Pixels before that cycle use the old set.
- R9: cfg_enable and cfg_extended are sampled only on frame_start. A change of these inputs between strobes has no effect on the output.
- R10: Exchanging coefficient columns 1 and 2 while feeding the two chroma inputs in swapped order gives the same outputs as the unswapped set with normal input order.
- R11: With a full-range BT.601 YCbCr-to-RGB set (chroma centred on 512), black, white and the three primaries match the ideal conversion within 1 LSB in both formats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Coefficient word write strobe |
| wr_idx | input | 4 | Coefficient word index (0..11 valid) |
| wr_data | input | 32 | Coefficient word value |
| cfg_enable | input | 1 | Conversion enable, sampled on frame_start |
| cfg_extended | input | 1 | Format select (0 fixed-offset, 1 offset-pair), sampled on frame_start |
| frame_start | input | 1 | Activates staged coefficients and configuration |
| in_valid | input | 1 | Input pixel valid |
| in_c0 | input | 10 | Input component x (luma) |
| in_c1 | input | 10 | Input component y (first chroma) |
| in_c2 | input | 10 | Input component z (second chroma) |
| out_valid | output | 1 | Output pixel valid |
| out_c0 | output | 10 | Output row 0 |
| out_c1 | output | 10 | Output row 1 |
| out_c2 | output | 10 | Output row 2 |

## Verification
Several properties are checked on every cycle. These are the three-cycle valid latency, the exact pass-through when disabled, the stability of the active coefficient bank between strobes, the rejection of out-of-range write indices, and the forcing of a negative row sum to zero. Other behaviour needs the bench's scenarios against a reference model: the arithmetic of both formats, the packing of offset and constant, round-half-up, the upper clamp, same-cycle strobe activation, column swapping, and closeness to the ideal BT.601 conversion.

// File: rtl/csc_pkg.sv
package csc_pkg;
   localparam int CSC_ROWS  = 3;
   localparam int CSC_COLS  = 4;
   localparam int CSC_WORDS = CSC_ROWS * CSC_COLS;
   localparam int CSC_IDX_W = $clog2(CSC_WORDS);

   typedef enum logic {
      FMT_FIXED_OFS = 1'b0,
      FMT_OFS_PAIR  = 1'b1
   } csc_fmt_e;
endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank #(
   parameter int NW     = 12,
   parameter int WORD_W = 32,
   parameter int IDX_W  = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [IDX_W-1:0]             wr_idx,
   input  logic [WORD_W-1:0]            wr_data,
   input  logic                         cfg_en,
   input  logic                         cfg_ext,
   input  logic                         frame_start,
   output logic [NW-1:0][WORD_W-1:0]    eff_w,
   output logic                         eff_en,
   output logic                         eff_ext
);
   logic [WORD_W-1:0] stg_q [NW];
   logic [WORD_W-1:0] act_q [NW];
   logic              act_en_q;
   logic              act_ext_q;

   generate
      for (genvar w = 0; w < NW; w++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_q[w] <= '0;
               act_q[w] <= '0;
            end else begin
               if (wr_en && (int'(wr_idx) == w)) stg_q[w] <= wr_data;
               if (frame_start)                   act_q[w] <= stg_q[w];
            end
         end
         assign eff_w[w] = frame_start ? stg_q[w] : act_q[w];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_en_q  <= 1'b0;
         act_ext_q <= 1'b0;
      end else if (frame_start) begin
         act_en_q  <= cfg_en;
         act_ext_q <= cfg_ext;
      end
   end

   assign eff_en  = frame_start ? cfg_en  : act_en_q;
   assign eff_ext = frame_start ? cfg_ext : act_ext_q;

   // R8: active set and configuration move only on the frame strobe
   a_r8_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> ($stable(act_en_q) && $stable(act_ext_q) &&
                        $stable(act_q[0]) && $stable(act_q[NW-1])));

   // R7: an index beyond the last word leaves the staging bank untouched
   a_r7_ignore_high_idx: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_idx) >= NW) |=> ($stable(stg_q[0]) && $stable(stg_q[NW-1])));
endmodule

// File: rtl/csc_row.sv
module csc_row #(
   parameter int PIX_W    = 10,
   parameter int WORD_W   = 32,
   parameter int A_W      = 17,
   parameter int ACC_W    = 51,
   parameter int LEG_FRAC = 10,
   parameter int EXT_FRAC = 17
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [A_W-1:0]    adj   [3],
   input  logic signed [WORD_W-1:0] coef  [3],
   input  logic signed [ACC_W-1:0]  kterm,
   input  logic                     ext_s2,
   output logic [PIX_W-1:0]         y
);
   localparam int P_W = WORD_W + A_W;
   localparam logic signed [ACC_W-1:0] HALF_L = ACC_W'(1) <<< (LEG_FRAC - 1);
   localparam logic signed [ACC_W-1:0] HALF_E = ACC_W'(1) <<< (EXT_FRAC - 1);
   localparam logic signed [ACC_W-1:0] MAXV   = ACC_W'((1 << PIX_W) - 1);

   logic signed [P_W-1:0]   prod_q [3];
   logic signed [ACC_W-1:0] k_q;
   logic signed [ACC_W-1:0] sum_q;
   logic signed [ACC_W-1:0] rnd;
   logic signed [ACC_W-1:0] shf;
   logic [PIX_W-1:0]        sat;

   // stage 1: products
   generate
      for (genvar j = 0; j < 3; j++) begin : g_mul
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prod_q[j] <= '0;
            else        prod_q[j] <= coef[j] * adj[j];
         end
      end
   endgenerate

   // stage 2: sum
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k_q   <= '0;
         sum_q <= '0;
      end else begin
         k_q   <= kterm;
         sum_q <= ACC_W'(prod_q[0]) + ACC_W'(prod_q[1]) + ACC_W'(prod_q[2]) + k_q;
      end
   end

   // stage 3: round to nearest, drop fraction, saturate
   always_comb begin
      rnd = sum_q + (ext_s2 ? HALF_E : HALF_L);
      shf = ext_s2 ? (rnd >>> EXT_FRAC) : (rnd >>> LEG_FRAC);
      if (shf < 0)         sat = '0;
      else if (shf > MAXV) sat = '1;
      else                 sat = shf[PIX_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) y <= '0;
      else        y <= sat;
   end

   // R4: a negative accumulated sum can only yield zero
   a_r4_negative_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_q < 0) |=> (y == '0));
endmodule

// File: rtl/csc_matrix3.sv
module csc_matrix3
   import csc_pkg::*;
#(
   parameter int PIX_W    = 10,
   parameter int WORD_W   = 32,
   parameter int LEG_FRAC = 10,
   parameter int EXT_FRAC = 17
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [CSC_IDX_W-1:0] wr_idx,
   input  logic [WORD_W-1:0]    wr_data,
   input  logic                 cfg_enable,
   input  logic                 cfg_extended,
   input  logic                 frame_start,
   input  logic                 in_valid,
   input  logic [PIX_W-1:0]     in_c0,
   input  logic [PIX_W-1:0]     in_c1,
   input  logic [PIX_W-1:0]     in_c2,
   output logic                 out_valid,
   output logic [PIX_W-1:0]     out_c0,
   output logic [PIX_W-1:0]     out_c1,
   output logic [PIX_W-1:0]     out_c2
);
   localparam int HALF_W = WORD_W / 2;
   localparam int A_W    = HALF_W + 1;
   localparam int ACC_W  = WORD_W + A_W + 2;

   generate
      if (PIX_W < 2 || PIX_W >= HALF_W) begin : g_bad_pix
         $error("csc_matrix3: PIX_W must lie in 2..WORD_W/2-1");
      end
      if (WORD_W % 2 != 0 || WORD_W < 8) begin : g_bad_word
         $error("csc_matrix3: WORD_W must be even and at least 8");
      end
      if (LEG_FRAC < 1 || EXT_FRAC < 1 || EXT_FRAC + HALF_W >= ACC_W) begin : g_bad_frac
         $error("csc_matrix3: fractional widths out of range");
      end
   endgenerate

   logic [CSC_WORDS-1:0][WORD_W-1:0] eff_w;
   logic eff_en, eff_ext;

   csc_coef_bank #(.NW(CSC_WORDS), .WORD_W(WORD_W), .IDX_W(CSC_IDX_W)) u_bank (
      .clk, .rst_n, .wr_en, .wr_idx, .wr_data,
      .cfg_en(cfg_enable), .cfg_ext(cfg_extended), .frame_start,
      .eff_w, .eff_en, .eff_ext
   );

   logic [PIX_W-1:0]        pix [3];
   logic signed [A_W-1:0]   adj [3];
   logic [PIX_W-1:0]        row_y [3];

   assign pix[0] = in_c0;
   assign pix[1] = in_c1;
   assign pix[2] = in_c2;

   // input offsets: row j's fourth word carries the offset of input j
   generate
      for (genvar j = 0; j < 3; j++) begin : g_adj
         logic signed [A_W-1:0] pix_s, dif_s;
         logic [HALF_W-1:0]     dif;
         assign dif   = eff_w[CSC_COLS*j + 3][WORD_W-1:HALF_W];
         assign pix_s = $signed({{(A_W-PIX_W){1'b0}}, pix[j]});
         assign dif_s = $signed({dif[HALF_W-1], dif});
         assign adj[j] = (eff_ext == FMT_OFS_PAIR) ? (pix_s + dif_s) : pix_s;
      end
   endgenerate

   // pipeline control, alongside the row datapaths
   logic            v1, v2, v3, en1, en2, en3, ext1, ext2;
   logic [PIX_W-1:0] pass1 [3];
   logic [PIX_W-1:0] pass2 [3];
   logic [PIX_W-1:0] pass3 [3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {v1, v2, v3}    <= '0;
         {en1, en2, en3} <= '0;
         {ext1, ext2}    <= '0;
         for (int j = 0; j < 3; j++) begin
            pass1[j] <= '0;
            pass2[j] <= '0;
            pass3[j] <= '0;
         end
      end else begin
         v1 <= in_valid;   v2 <= v1;     v3 <= v2;
         en1 <= eff_en;    en2 <= en1;   en3 <= en2;
         ext1 <= eff_ext;  ext2 <= ext1;
         for (int j = 0; j < 3; j++) begin
            pass1[j] <= pix[j];
            pass2[j] <= pass1[j];
            pass3[j] <= pass2[j];
         end
      end
   end

   generate
      for (genvar i = 0; i < CSC_ROWS; i++) begin : g_row
         logic signed [WORD_W-1:0] cf [3];
         logic signed [ACC_W-1:0]  kt;
         logic [WORD_W-1:0]        kw;
         for (genvar j = 0; j < 3; j++) begin : g_cf
            assign cf[j] = $signed(eff_w[CSC_COLS*i + j]);
         end
         assign kw = eff_w[CSC_COLS*i + 3];
         assign kt = (eff_ext == FMT_OFS_PAIR)
                   ? ($signed({{(ACC_W-HALF_W){kw[HALF_W-1]}}, kw[HALF_W-1:0]}) <<< EXT_FRAC)
                   : $signed({{(ACC_W-WORD_W){kw[WORD_W-1]}}, kw});
         csc_row #(
            .PIX_W(PIX_W), .WORD_W(WORD_W), .A_W(A_W), .ACC_W(ACC_W),
            .LEG_FRAC(LEG_FRAC), .EXT_FRAC(EXT_FRAC)
         ) u_row (
            .clk, .rst_n, .adj, .coef(cf), .kterm(kt), .ext_s2(ext2), .y(row_y[i])
         );
      end
   endgenerate

   assign out_valid = v3;
   assign out_c0    = en3 ? row_y[0] : pass3[0];
   assign out_c1    = en3 ? row_y[1] : pass3[1];
   assign out_c2    = en3 ? row_y[2] : pass3[2];

   // R5: every accepted pixel leaves exactly three cycles later
   a_r5_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##3 out_valid);
   // R5: no output without a matching input
   a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##3 !out_valid);
   // R6: a disabled converter returns the input unchanged
   a_r6_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !eff_en) |-> ##3 (out_c0 == $past(in_c0, 3) &&
                                     out_c1 == $past(in_c1, 3) &&
                                     out_c2 == $past(in_c2, 3)));
endmodule

// File: tb/tb_csc_matrix3.sv
module tb_csc_matrix3;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic        cfg_enable = 1'b0, cfg_extended = 1'b0, frame_start = 1'b0;
   logic        in_valid = 1'b0;
   logic [9:0]  in_c0 = '0, in_c1 = '0, in_c2 = '0;
   logic        out_valid;
   logic [9:0]  out_c0, out_c1, out_c2;

   csc_matrix3 dut (
      .clk, .rst_n, .wr_en, .wr_idx, .wr_data, .cfg_enable, .cfg_extended,
      .frame_start, .in_valid, .in_c0, .in_c1, .in_c2,
      .out_valid, .out_c0, .out_c1, .out_c2
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int errors = 0, checks = 0;
   bit done = 0;

   logic [31:0] stg_w [12];
   logic [31:0] act_w [12];
   bit act_en = 0, act_ext = 0;

   int    q_stamp[$], q_e0[$], q_e1[$], q_e2[$], q_i0[$], q_i1[$], q_i2[$], q_use[$];
   string q_tag[$];

   task automatic check(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // reference model written from R1..R4, R6
   function automatic int ref_out(int ch, int x0, int x1, int x2);
      int xs[3];
      longint a, acc;
      int fr;
      xs[0] = x0; xs[1] = x1; xs[2] = x2;
      if (!act_en) return xs[ch];
      acc = 0;
      for (int j = 0; j < 3; j++) begin
         a = xs[j];
         if (act_ext) a += longint'($signed(act_w[4*j+3][31:16]));
         acc += longint'($signed(act_w[4*ch+j])) * a;
      end
      if (act_ext) begin
         acc += longint'($signed(act_w[4*ch+3][15:0])) * 131072;
         fr = 17;
      end else begin
         acc += longint'($signed(act_w[4*ch+3]));
         fr = 10;
      end
      acc = (acc + (longint'(1) <<< (fr - 1))) >>> fr;
      if (acc < 0) return 0;
      if (acc > 1023) return 1023;
      return int'(acc);
   endfunction

   // ideal full-range BT.601 conversion for R11
   function automatic int ideal(int ch, int y, int u, int v);
      real r;
      int n;
      case (ch)
         0:       r = y + 1.402 * (v - 512);
         1:       r = y - 0.344136 * (u - 512) - 0.714136 * (v - 512);
         default: r = y + 1.772 * (u - 512);
      endcase
      n = $rtoi($floor(r + 0.5));
      if (n < 0) n = 0;
      if (n > 1023) n = 1023;
      return n;
   endfunction

   task automatic write_word(int idx, logic [31:0] d);
      wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
      if (idx < 12) stg_w[idx] = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic activate();
      act_w = stg_w; act_en = cfg_enable; act_ext = cfg_extended;
   endtask

   task automatic pulse_fs();
      activate();
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   // drive one pixel; sw means chroma fed in swapped order (ideal uses original order)
   task automatic send(int y, int u, int v, bit fs, bit use_ideal, bit sw, string tag);
      if (fs) activate();
      frame_start = fs;
      in_valid = 1'b1; in_c0 = 10'(y); in_c1 = 10'(u); in_c2 = 10'(v);
      q_stamp.push_back(cyc);
      q_e0.push_back(ref_out(0, y, u, v));
      q_e1.push_back(ref_out(1, y, u, v));
      q_e2.push_back(ref_out(2, y, u, v));
      q_i0.push_back(sw ? ideal(0, y, v, u) : ideal(0, y, u, v));
      q_i1.push_back(sw ? ideal(1, y, v, u) : ideal(1, y, u, v));
      q_i2.push_back(sw ? ideal(2, y, v, u) : ideal(2, y, u, v));
      q_use.push_back(int'(use_ideal));
      q_tag.push_back(tag);
      @(negedge clk);
      in_valid = 1'b0; frame_start = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load_bt601(bit ext, bit swap);
      int c[3][3];
      int t;
      if (!ext) begin
         c = '{'{1024, 0, 1436}, '{1024, -352, -731}, '{1024, 1815, 0}};
      end else begin
         c = '{'{131072, 0, 183763}, '{131072, -45107, -93603}, '{131072, 232260, 0}};
      end
      for (int i = 0; i < 3; i++) begin
         if (swap) begin t = c[i][1]; c[i][1] = c[i][2]; c[i][2] = t; end
         for (int j = 0; j < 3; j++) write_word(4*i + j, 32'(c[i][j]));
      end
      if (!ext) begin
         write_word(3, 32'(-735232)); write_word(7, 32'(554496)); write_word(11, 32'(-929280));
      end else begin
         write_word(3, 32'h0000_0000); write_word(7, 32'hFE00_0000); write_word(11, 32'hFE00_0000);
      end
   endtask

   task automatic colors(string tag);
      send(0,    512, 512,  0, 1, 0, tag);  // black
      send(1023, 512, 512,  0, 1, 0, tag);  // white
      send(306,  339, 1023, 0, 1, 0, tag);  // red
      send(601,  173, 84,   0, 1, 0, tag);  // green
      send(117,  1023, 429, 0, 1, 0, tag);  // blue
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_valid) begin
            if (q_stamp.size() == 0) begin
               check(0, "R5", "out_valid without input", 1, 0);
            end else begin
               int st, e0, e1, e2, i0, i1, i2, u;
               string tg;
               st = q_stamp.pop_front(); e0 = q_e0.pop_front(); e1 = q_e1.pop_front();
               e2 = q_e2.pop_front(); i0 = q_i0.pop_front(); i1 = q_i1.pop_front();
               i2 = q_i2.pop_front(); u = q_use.pop_front(); tg = q_tag.pop_front();
               check(cyc == st + 3, "R5", "latency", cyc - st, 3);
               check(int'(out_c0) == e0, tg, "out_c0", int'(out_c0), e0);
               check(int'(out_c1) == e1, tg, "out_c1", int'(out_c1), e1);
               check(int'(out_c2) == e2, tg, "out_c2", int'(out_c2), e2);
               if (u != 0) begin
                  check((int'(out_c0) - i0) <= 1 && (i0 - int'(out_c0)) <= 1, "R11", "ideal c0", int'(out_c0), i0);
                  check((int'(out_c1) - i1) <= 1 && (i1 - int'(out_c1)) <= 1, "R11", "ideal c1", int'(out_c1), i1);
                  check((int'(out_c2) - i2) <= 1 && (i2 - int'(out_c2)) <= 1, "R11", "ideal c2", int'(out_c2), i2);
               end
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R5 watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 12; k++) begin stg_w[k] = '0; act_w[k] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R5, R6)
      check(out_valid == 1'b0, "R5", "reset out_valid", int'(out_valid), 0);
      check(out_c0 == 10'd0, "R6", "reset out_c0", int'(out_c0), 0);

      // R6: disabled after reset, pixels pass through
      send(17, 900, 3, 0, 0, 0, "R6");
      send(1023, 0, 512, 0, 0, 0, "R6");
      idle(4);

      // R1, R11: fixed-offset BT.601, activated by a standalone strobe
      load_bt601(0, 0);
      cfg_enable = 1; cfg_extended = 0;
      pulse_fs();
      colors("R1");
      idle(2);
      // R4: saturation both ways
      send(1023, 512, 1023, 0, 0, 0, "R4");
      send(0, 0, 0, 0, 0, 0, "R4");
      idle(4);

      // R2, R11: offset-pair BT.601; pixel shares the strobe cycle (R8)
      load_bt601(1, 0);
      cfg_extended = 1;
      send(0, 512, 512, 1, 1, 0, "R8");
      colors("R2");
      idle(4);

      // R2: offset/constant packing: out0=y+5, out1=u-10, out2=v+20-3
      for (int k = 0; k < 12; k++) write_word(k, 32'h0);
      write_word(0, 32'd131072);  write_word(3,  32'h0000_0005);
      write_word(5, 32'd131072);  write_word(7,  32'hFFF6_0000);
      write_word(10, 32'd131072); write_word(11, 32'h0014_FFFD);
      pulse_fs();
      send(100, 200, 300, 0, 0, 0, "R2");   // 105, 190, 317
      send(1020, 5, 0, 0, 0, 0, "R2");      // 1023 (clamp), 0 (clamp), 17
      idle(4);

      // R3: half-LSB rounding in fixed-offset format with 0.5 gains
      for (int k = 0; k < 12; k++) write_word(k, 32'h0);
      write_word(0, 32'd512); write_word(5, 32'd512); write_word(10, 32'd512);
      cfg_extended = 0;
      pulse_fs();
      send(1, 3, 5, 0, 0, 0, "R3");         // 1, 2, 3
      send(0, 1022, 1023, 0, 0, 0, "R3");   // 0, 511, 512
      idle(4);

      // R8: staged writes have no effect until the strobe
      write_word(0, 32'd1024);
      send(7, 9, 11, 0, 0, 0, "R8");        // still 0.5 gain on row 0
      send(7, 9, 11, 1, 0, 0, "R8");        // new gain in the strobe cycle
      idle(4);

      // R9: enable/format changes between strobes are ignored
      cfg_enable = 0; cfg_extended = 1;
      send(40, 60, 80, 0, 0, 0, "R9");
      send(40, 60, 80, 1, 0, 0, "R9");      // now disabled: pass-through
      idle(4);

      // R7: high indices do not alias onto real words
      cfg_enable = 1; cfg_extended = 0;
      write_word(12, 32'h7FFF_FFFF);
      write_word(13, 32'h7FFF_FFFF);
      write_word(15, 32'h8000_0000);
      pulse_fs();
      send(40, 60, 80, 0, 0, 0, "R7");      // 40, 30, 40
      idle(4);

      // R10, R11: swapped chroma columns with swapped inputs
      load_bt601(0, 1);
      pulse_fs();
      send(306, 1023, 339, 0, 1, 1, "R10");
      send(117, 429, 1023, 0, 1, 1, "R10");
      load_bt601(1, 1);
      cfg_extended = 1;
      pulse_fs();
      send(601, 84, 173, 0, 1, 1, "R10");
      idle(6);

      check(q_stamp.size() == 0, "R5", "outputs outstanding", q_stamp.size(), 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule